// File: doc/BRIEF.md
# Snooping MOSI Line Coherence Controller

This block tracks the coherence state of one line held by a private cache that sits on a broadcast snooping bus. It keeps the stable states NP, I, S, O and M. While a request is in flight it keeps two facts apart: whether the cache has yet seen its own request in the globally ordered address stream, and whether the data has yet arrived. Either may come first. A single transaction buffer holds in-flight data, the pending store value and a mask of other nodes whose requests were snooped while data was still outstanding. When the data lands, it is forwarded to those nodes.

Three channels feed the controller: processor operations, snooped address-bus requests tagged as own or other, and data-network arrivals. Each channel uses a valid/ready handshake. The controller takes at most one event per clock. It answers with bus requests, data responses, load and store completion pulses, a retry pulse for processor operations that reach a busy line, an access-permission code and a sticky protocol-error flag. All pulse outputs are registered and appear in the cycle after the accepting clock edge.

Top module: `mosi_line_ctrl`

## Requirements
- R1: After reset the line is not present: `perm` is 0 (Invalid), `proto_err` is 0, and no pulse output is active.
- R2: At most one event is accepted per cycle. `snp_ready` is always 1, `dat_ready` is 1 only when `snp_valid` is 0, and `cpu_ready` is 1 only when both `snp_valid` and `dat_valid` are 0.
- R3: The `cpu_op` codes are 0 load, 1 ifetch, 2 store and 3 evict. The bus kinds on `snp_kind` and `req_kind` are 0 read-shared, 1 instruction-read, 2 read-exclusive and 3 writeback. In NP or I, a load issues kind 0, an ifetch issues kind 1 and a store issues kind 2. After each of these, `perm` reads Busy.
- R4: When the own request is seen before the data, the data arrival completes the operation. A read ends in S and pulses `load_done` with the arrived data. A store ends in M and pulses `store_done`.
- R5: When data arrives before the own request is seen, the data is held and nothing completes. Observing the own request then completes the operation: a read gives `load_done` with the held data, and a store gives `store_done`.
- R6: A load or ifetch in S, O or M pulses `load_done` with the line data. A store in M pulses `store_done` and replaces the line data with `cpu_wdata`.
- R7: Another node's read in M gets a response with the line data, one-hot to that node, and the line moves to O. Another node's read-exclusive in M or O gets a response and the line moves to I. In S, another node's read-exclusive moves the line to I, and another node's reads leave it in S.
- R8: A store in S or O issues kind 2. If another node's read-exclusive is snooped before the own request, an owned line answers it with the line data and then waits for fresh data.
- R9: An evict in M or O issues kind 3 carrying the line data. Until the own writeback is seen, other nodes' reads and read-exclusives are answered from the buffer. Seeing the own writeback leaves the line in I.
- R10: While a store waits for data after its own request was seen, every other node's request is recorded. On data arrival the store completes and one response carries the store value to all recorded nodes. The line ends in O if only reads were recorded, and in I if any read-exclusive was recorded.
- R11: A read waiting for data after its own request was seen, which then snoops another node's read-exclusive, still completes its load on data arrival but ends in I.
- R12: Another node's writeback has no effect in any state. A processor operation accepted in a transient state pulses `cpu_retry` and changes nothing else.
- R13: `perm` is 0 (Invalid) in NP, I, in an M writeback and after a lost writeback; 1 (Read-only) in S and O; 2 (Read-write) in M; and 3 (Busy) in every other state.
- R14: `proto_err` sets and stays set when data arrives in a state not waiting for it, or when an own request is seen in a state not expecting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor operation present |
| cpu_ready | output | 1 | Processor operation accepted this cycle |
| cpu_op | input | 2 | Operation code (R3) |
| cpu_wdata | input | DW | Store value |
| cpu_retry | output | 1 | Operation must be re-presented later |
| load_done | output | 1 | Load or ifetch completed |
| load_data | output | DW | Data returned with `load_done` |
| store_done | output | 1 | Store completed |
| snp_valid | input | 1 | Snooped bus request present |
| snp_ready | output | 1 | Snooped request accepted |
| snp_kind | input | 2 | Snooped request kind (R3) |
| snp_own | input | 1 | Request was issued by this cache |
| snp_src | input | NODE_W | Requesting node number |
| dat_valid | input | 1 | Data arrival present |
| dat_ready | output | 1 | Data arrival accepted |
| dat_data | input | DW | Arriving line data |
| req_valid | output | 1 | Bus request issued |
| req_kind | output | 2 | Issued request kind |
| req_data | output | DW | Writeback data (kind 3) |
| rsp_valid | output | 1 | Data response issued |
| rsp_dest | output | 2**NODE_W | Destination node mask |
| rsp_data | output | DW | Response data |
| perm | output | 2 | Access permission code (R13) |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The assertions assume that the network never delivers data to a line that is not waiting for it, and that the own request of each transaction appears exactly once, so forwarding is recorded only while a store is outstanding. The stimulus follows the legal order of a single transaction: one request is issued and completed before the next begins. The only deliberate exceptions are the data arrival in I, which exercises the sticky error flag, and the simultaneous snoop-plus-processor cycle, which exercises the arbitration.

// File: rtl/mosi_pkg.sv
package mosi_pkg;

  typedef enum logic [4:0] {
    ST_NP, ST_I, ST_S, ST_O, ST_M,
    ST_IS_AD, ST_IM_AD, ST_SM_AD, ST_OM_A,
    ST_IS_A, ST_IM_A, ST_SM_A,
    ST_MI_A, ST_OI_A, ST_II_A,
    ST_IS_D, ST_IS_D_I,
    ST_IM_D, ST_IM_D_O, ST_IM_D_I, ST_IM_D_OI,
    ST_SM_D, ST_SM_D_O
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_IFETCH = 2'd1, OP_STORE = 2'd2, OP_EVICT = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    BK_GETS = 2'd0, BK_GETI = 2'd1, BK_GETX = 2'd2, BK_PUTX = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    PM_INVALID = 2'd0, PM_READ = 2'd1, PM_RW = 2'd2, PM_BUSY = 2'd3
  } perm_e;

  function automatic perm_e perm_of(line_st_e s);
    case (s)
      ST_NP, ST_I, ST_MI_A, ST_II_A: perm_of = PM_INVALID;
      ST_S, ST_O:                    perm_of = PM_READ;
      ST_M:                          perm_of = PM_RW;
      default:                       perm_of = PM_BUSY;
    endcase
  endfunction

  function automatic logic is_stable(line_st_e s);
    is_stable = (s == ST_NP) || (s == ST_I) || (s == ST_S) ||
                (s == ST_O) || (s == ST_M);
  endfunction

  function automatic logic is_read_kind(bus_kind_e k);
    is_read_kind = (k == BK_GETS) || (k == BK_GETI);
  endfunction

endpackage

// File: rtl/mosi_evt_arb.sv
module mosi_evt_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic snp_valid,
  input  logic dat_valid,
  input  logic cpu_valid,
  output logic snp_ready,
  output logic dat_ready,
  output logic cpu_ready,
  output logic snp_acc,
  output logic dat_acc,
  output logic cpu_acc
);
  // Fixed priority: address bus first, then data network, then processor.
  assign snp_ready = 1'b1;
  assign dat_ready = ~snp_valid;
  assign cpu_ready = ~snp_valid & ~dat_valid;

  assign snp_acc = snp_valid & snp_ready;
  assign dat_acc = dat_valid & dat_ready;
  assign cpu_acc = cpu_valid & cpu_ready;

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snp_acc, dat_acc, cpu_acc}));

  assert_snoop_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!cpu_acc && !dat_acc));
endmodule

// File: rtl/mosi_txn_buf.sv
module mosi_txn_buf #(
  parameter int DW      = 32,
  parameter int NODE_W  = 3,
  parameter int N_NODES = 1 << NODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DW-1:0]     cap_data,
  input  logic              st_en,
  input  logic [DW-1:0]     st_data,
  input  logic              fwd_add,
  input  logic [NODE_W-1:0] fwd_src,
  input  logic              fwd_clr,
  output logic [DW-1:0]     buf_data,
  output logic [DW-1:0]     st_data_q,
  output logic [N_NODES-1:0] fwd_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data  <= '0;
      st_data_q <= '0;
    end else begin
      if (cap_en) buf_data  <= cap_data;
      if (st_en)  st_data_q <= st_data;
    end
  end

  // One recording flop per possible requesting node.
  for (genvar n = 0; n < N_NODES; n++) begin : g_fwd
    always_ff @(posedge clk) begin
      if (!rst_n || fwd_clr)
        fwd_mask[n] <= 1'b0;
      else if (fwd_add && (fwd_src == NODE_W'(n)))
        fwd_mask[n] <= 1'b1;
    end
  end

  assert_fwd_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_add && !fwd_clr) |=> fwd_mask[$past(fwd_src)]);
endmodule

// File: rtl/mosi_line_fsm.sv
module mosi_line_fsm
  import mosi_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NODE_W  = 3,
  parameter int N_NODES = 1 << NODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_acc,
  input  logic               snp_own,
  input  logic [1:0]         snp_kind,
  input  logic [NODE_W-1:0]  snp_src,
  input  logic               dat_acc,
  input  logic [DW-1:0]      dat_data,
  input  logic               cpu_acc,
  input  logic [1:0]         cpu_op,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic [DW-1:0]      buf_data,
  input  logic [DW-1:0]      st_data_q,
  input  logic [N_NODES-1:0] fwd_mask,
  output logic               cap_en,
  output logic [DW-1:0]      cap_data,
  output logic               st_en,
  output logic               fwd_add,
  output logic               fwd_clr,
  output logic [1:0]         perm,
  output logic               req_valid,
  output logic [1:0]         req_kind,
  output logic [DW-1:0]      req_data,
  output logic               rsp_valid,
  output logic [N_NODES-1:0] rsp_dest,
  output logic [DW-1:0]      rsp_data,
  output logic               load_done,
  output logic [DW-1:0]      load_data,
  output logic               store_done,
  output logic               cpu_retry,
  output logic               proto_err
);
  localparam logic [N_NODES-1:0] ONE_HOT0 = {{(N_NODES-1){1'b0}}, 1'b1};

  line_st_e st_q, st_d;
  logic [DW-1:0] line_q;

  // Decoded events, kept as named wires for the checks below.
  bus_kind_e     kind;
  cpu_op_e       op;
  logic          ev_rd_other, ev_x_other, ev_own;
  logic [N_NODES-1:0] src_hot;

  assign kind        = bus_kind_e'(snp_kind);
  assign op          = cpu_op_e'(cpu_op);
  assign ev_own      = snp_acc & snp_own;
  assign ev_rd_other = snp_acc & ~snp_own & is_read_kind(kind);
  assign ev_x_other  = snp_acc & ~snp_own & (kind == BK_GETX);
  assign src_hot     = ONE_HOT0 << snp_src;

  logic              n_req, n_rsp, n_ld, n_st, n_retry, n_err, line_we;
  bus_kind_e         n_rk;
  logic [DW-1:0]     n_rd, n_rdat, n_ldd, line_wd;
  logic [N_NODES-1:0] n_dst;

  always_comb begin
    st_d = st_q;
    n_req = 1'b0; n_rk = BK_GETS; n_rd = '0;
    n_rsp = 1'b0; n_dst = '0; n_rdat = '0;
    n_ld = 1'b0; n_ldd = '0; n_st = 1'b0; n_retry = 1'b0; n_err = 1'b0;
    line_we = 1'b0; line_wd = '0;
    cap_en = 1'b0; cap_data = '0; st_en = 1'b0; fwd_add = 1'b0; fwd_clr = 1'b0;

    if (cpu_acc) begin
      if (!is_stable(st_q)) begin
        n_retry = 1'b1;
      end else begin
        case (st_q)
          ST_NP, ST_I: begin
            case (op)
              OP_LOAD:   begin n_req = 1'b1; n_rk = BK_GETS; st_d = ST_IS_AD; fwd_clr = 1'b1; end
              OP_IFETCH: begin n_req = 1'b1; n_rk = BK_GETI; st_d = ST_IS_AD; fwd_clr = 1'b1; end
              OP_STORE:  begin
                n_req = 1'b1; n_rk = BK_GETX; st_d = ST_IM_AD; st_en = 1'b1; fwd_clr = 1'b1;
              end
              OP_EVICT:  st_d = ST_NP;
            endcase
          end
          ST_S: begin
            case (op)
              OP_LOAD, OP_IFETCH: begin n_ld = 1'b1; n_ldd = line_q; end
              OP_STORE: begin
                n_req = 1'b1; n_rk = BK_GETX; st_d = ST_SM_AD; st_en = 1'b1; fwd_clr = 1'b1;
              end
              OP_EVICT: st_d = ST_NP;
            endcase
          end
          ST_O, ST_M: begin
            case (op)
              OP_LOAD, OP_IFETCH: begin n_ld = 1'b1; n_ldd = line_q; end
              OP_STORE: begin
                if (st_q == ST_M) begin
                  n_st = 1'b1; line_we = 1'b1; line_wd = cpu_wdata;
                end else begin
                  n_req = 1'b1; n_rk = BK_GETX; st_d = ST_OM_A; st_en = 1'b1; fwd_clr = 1'b1;
                end
              end
              OP_EVICT: begin
                n_req = 1'b1; n_rk = BK_PUTX; n_rd = line_q;
                cap_en = 1'b1; cap_data = line_q; fwd_clr = 1'b1;
                st_d = (st_q == ST_M) ? ST_MI_A : ST_OI_A;
              end
            endcase
          end
          default: ;
        endcase
      end
    end else if (dat_acc) begin
      case (st_q)
        ST_IS_AD: begin cap_en = 1'b1; cap_data = dat_data; st_d = ST_IS_A; end
        ST_IM_AD, ST_OM_A: begin cap_en = 1'b1; cap_data = dat_data; st_d = ST_IM_A; end
        ST_SM_AD: begin cap_en = 1'b1; cap_data = dat_data; st_d = ST_SM_A; end
        ST_IS_D, ST_IS_D_I: begin
          n_ld = 1'b1; n_ldd = dat_data; line_we = 1'b1; line_wd = dat_data;
          st_d = (st_q == ST_IS_D) ? ST_S : ST_I;
        end
        ST_IM_D, ST_SM_D: begin
          n_st = 1'b1; line_we = 1'b1; line_wd = st_data_q; st_d = ST_M;
        end
        ST_IM_D_O, ST_SM_D_O, ST_IM_D_I, ST_IM_D_OI: begin
          n_st = 1'b1; line_we = 1'b1; line_wd = st_data_q;
          n_rsp = 1'b1; n_dst = fwd_mask; n_rdat = st_data_q;
          st_d = ((st_q == ST_IM_D_O) || (st_q == ST_SM_D_O)) ? ST_O : ST_I;
        end
        default: n_err = 1'b1;
      endcase
    end else if (ev_own) begin
      case (st_q)
        ST_IS_AD: if (is_read_kind(kind)) st_d = ST_IS_D; else n_err = 1'b1;
        ST_IS_A: begin
          if (is_read_kind(kind)) begin
            n_ld = 1'b1; n_ldd = buf_data; line_we = 1'b1; line_wd = buf_data; st_d = ST_S;
          end else n_err = 1'b1;
        end
        ST_IM_AD: if (kind == BK_GETX) st_d = ST_IM_D; else n_err = 1'b1;
        ST_SM_AD: if (kind == BK_GETX) st_d = ST_SM_D; else n_err = 1'b1;
        ST_OM_A, ST_IM_A, ST_SM_A: begin
          if (kind == BK_GETX) begin
            n_st = 1'b1; line_we = 1'b1; line_wd = st_data_q; st_d = ST_M;
          end else n_err = 1'b1;
        end
        ST_MI_A, ST_OI_A, ST_II_A: if (kind == BK_PUTX) st_d = ST_I; else n_err = 1'b1;
        default: n_err = 1'b1;
      endcase
    end else if (ev_rd_other || ev_x_other) begin
      case (st_q)
        ST_S:     if (ev_x_other) st_d = ST_I;
        ST_O:     begin n_rsp = 1'b1; n_dst = src_hot; n_rdat = line_q; if (ev_x_other) st_d = ST_I; end
        ST_M:     begin n_rsp = 1'b1; n_dst = src_hot; n_rdat = line_q; st_d = ev_x_other ? ST_I : ST_O; end
        ST_OM_A:  begin n_rsp = 1'b1; n_dst = src_hot; n_rdat = line_q; if (ev_x_other) st_d = ST_IM_AD; end
        ST_SM_AD: if (ev_x_other) st_d = ST_IM_AD;
        ST_SM_A:  if (ev_x_other) st_d = ST_IM_A;
        ST_MI_A, ST_OI_A: begin
          n_rsp = 1'b1; n_dst = src_hot; n_rdat = buf_data; if (ev_x_other) st_d = ST_II_A;
        end
        ST_IS_D:   if (ev_x_other) st_d = ST_IS_D_I;
        ST_IM_D:   begin fwd_add = 1'b1; st_d = ev_x_other ? ST_IM_D_I : ST_IM_D_O; end
        ST_IM_D_O: begin fwd_add = 1'b1; if (ev_x_other) st_d = ST_IM_D_OI; end
        ST_SM_D:   begin fwd_add = 1'b1; st_d = ev_x_other ? ST_IM_D_I : ST_SM_D_O; end
        ST_SM_D_O: begin fwd_add = 1'b1; if (ev_x_other) st_d = ST_IM_D_OI; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_NP; line_q <= '0;
      req_valid <= 1'b0; req_kind <= '0; req_data <= '0;
      rsp_valid <= 1'b0; rsp_dest <= '0; rsp_data <= '0;
      load_done <= 1'b0; load_data <= '0; store_done <= 1'b0;
      cpu_retry <= 1'b0; proto_err <= 1'b0;
    end else begin
      st_q <= st_d;
      if (line_we) line_q <= line_wd;
      req_valid <= n_req; req_kind <= n_rk; req_data <= n_rd;
      rsp_valid <= n_rsp; rsp_dest <= n_dst; rsp_data <= n_rdat;
      load_done <= n_ld; load_data <= n_ldd; store_done <= n_st;
      cpu_retry <= n_retry;
      proto_err <= proto_err | n_err;
    end
  end

  assign perm = perm_of(st_q);

  assert_store_settles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |-> (perm != PM_BUSY));
  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != BK_PUTX) |-> (perm == PM_BUSY));
  assert_wb_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == BK_PUTX) |-> (perm == PM_BUSY || perm == PM_INVALID));
  assert_done_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && store_done));
  assert_err_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  assert_rsp_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_dest != '0));
  assert_retry_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |-> (!req_valid && !load_done && !store_done));
endmodule

// File: rtl/mosi_line_ctrl.sv
module mosi_line_ctrl #(
  parameter int DW      = 32,
  parameter int NODE_W  = 3,
  localparam int N_NODES = 1 << NODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic [1:0]         cpu_op,
  input  logic [DW-1:0]      cpu_wdata,
  output logic               cpu_retry,
  output logic               load_done,
  output logic [DW-1:0]      load_data,
  output logic               store_done,
  input  logic               snp_valid,
  output logic               snp_ready,
  input  logic [1:0]         snp_kind,
  input  logic               snp_own,
  input  logic [NODE_W-1:0]  snp_src,
  input  logic               dat_valid,
  output logic               dat_ready,
  input  logic [DW-1:0]      dat_data,
  output logic               req_valid,
  output logic [1:0]         req_kind,
  output logic [DW-1:0]      req_data,
  output logic               rsp_valid,
  output logic [N_NODES-1:0] rsp_dest,
  output logic [DW-1:0]      rsp_data,
  output logic [1:0]         perm,
  output logic               proto_err
);
  logic snp_acc, dat_acc, cpu_acc;
  logic cap_en, st_en, fwd_add, fwd_clr;
  logic [DW-1:0] cap_data, buf_data, st_data_q;
  logic [N_NODES-1:0] fwd_mask;

  mosi_evt_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .dat_valid(dat_valid), .cpu_valid(cpu_valid),
    .snp_ready(snp_ready), .dat_ready(dat_ready), .cpu_ready(cpu_ready),
    .snp_acc(snp_acc), .dat_acc(dat_acc), .cpu_acc(cpu_acc)
  );

  mosi_txn_buf #(.DW(DW), .NODE_W(NODE_W), .N_NODES(N_NODES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cap_en(cap_en), .cap_data(cap_data),
    .st_en(st_en), .st_data(cpu_wdata),
    .fwd_add(fwd_add), .fwd_src(snp_src), .fwd_clr(fwd_clr),
    .buf_data(buf_data), .st_data_q(st_data_q), .fwd_mask(fwd_mask)
  );

  mosi_line_fsm #(.DW(DW), .NODE_W(NODE_W), .N_NODES(N_NODES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .snp_acc(snp_acc), .snp_own(snp_own), .snp_kind(snp_kind), .snp_src(snp_src),
    .dat_acc(dat_acc), .dat_data(dat_data),
    .cpu_acc(cpu_acc), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
    .buf_data(buf_data), .st_data_q(st_data_q), .fwd_mask(fwd_mask),
    .cap_en(cap_en), .cap_data(cap_data), .st_en(st_en),
    .fwd_add(fwd_add), .fwd_clr(fwd_clr), .perm(perm),
    .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_data(rsp_data),
    .load_done(load_done), .load_data(load_data), .store_done(store_done),
    .cpu_retry(cpu_retry), .proto_err(proto_err)
  );
endmodule

// File: tb/test_mosi_line_ctrl.sv
module test_mosi_line_ctrl;
  localparam int DW = 32;
  localparam int NODE_W = 3;
  localparam int NN = 1 << NODE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, snp_valid = 1'b0, dat_valid = 1'b0, snp_own = 1'b0;
  logic [1:0] cpu_op = '0, snp_kind = '0;
  logic [DW-1:0] cpu_wdata = '0, dat_data = '0;
  logic [NODE_W-1:0] snp_src = '0;
  logic cpu_ready, cpu_retry, load_done, store_done, snp_ready, dat_ready;
  logic req_valid, rsp_valid, proto_err;
  logic [1:0] req_kind, perm;
  logic [DW-1:0] load_data, req_data, rsp_data;
  logic [NN-1:0] rsp_dest;

  always #5 clk = ~clk;

  mosi_line_ctrl #(.DW(DW), .NODE_W(NODE_W)) i_mosi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
    .cpu_retry(cpu_retry), .load_done(load_done), .load_data(load_data), .store_done(store_done),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_kind(snp_kind), .snp_own(snp_own),
    .snp_src(snp_src), .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_data(rsp_data),
    .perm(perm), .proto_err(proto_err)
  );

  // Output item kinds: 0 request, 1 response, 2 load done, 3 store done, 4 retry.
  typedef struct { int kind; longint a; longint b; string tag; } item_t;
  item_t sb[$];
  int n_checks = 0, n_fail = 0;
  string last_tag = "R1";

  task automatic expect_item(input int k, input longint a, input longint b, input string tag);
    item_t it;
    it.kind = k; it.a = a; it.b = b; it.tag = tag;
    sb.push_back(it);
    last_tag = tag;
  endtask

  task automatic got(input int k, input longint a, input longint b);
    item_t e;
    n_checks++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL %s: unexpected output kind=%0d a=%0h b=%0h, expected none", last_tag, k, a, b);
    end else begin
      e = sb.pop_front();
      if (e.kind != k || e.a != a || e.b != b) begin
        n_fail++;
        $display("FAIL %s: got kind=%0d a=%0h b=%0h, expected kind=%0d a=%0h b=%0h",
                 e.tag, k, a, b, e.kind, e.a, e.b);
      end
    end
  endtask

  // Monitor: compares every output pulse with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid)  got(0, longint'(req_kind), (req_kind == 2'd3) ? longint'(req_data) : 0);
      if (rsp_valid)  got(1, longint'(rsp_dest), longint'(rsp_data));
      if (load_done)  got(2, longint'(load_data), 0);
      if (store_done) got(3, 0, 0);
      if (cpu_retry)  got(4, 0, 0);
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_perm(input int exp, input string tag);
    check(perm == 2'(exp), tag, longint'(perm), exp);
  endtask

  task automatic cpu(input int op, input logic [DW-1:0] wd);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'(op); cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic snp(input int k, input bit own, input int src);
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = 2'(k); snp_own = own; snp_src = NODE_W'(src);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic dat(input logic [DW-1:0] d);
    @(negedge clk);
    dat_valid = 1'b1; dat_data = d;
    @(negedge clk);
    dat_valid = 1'b0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_perm(0, "R1");
    check(proto_err == 1'b0, "R1", longint'(proto_err), 0);
    check(cpu_ready == 1'b1, "R1", longint'(cpu_ready), 1);

    // R3 / R4: load miss, own request first, then data
    expect_item(0, 0, 0, "R3"); cpu(0, '0); chk_perm(3, "R3");
    snp(0, 1, 0); chk_perm(3, "R13");
    expect_item(2, 'hA1, 0, "R4"); dat('hA1); chk_perm(1, "R4");

    // R6 hit in S, R7 shared snoops
    expect_item(2, 'hA1, 0, "R6"); cpu(1, '0);
    snp(0, 0, 4); chk_perm(1, "R7");
    snp(2, 0, 4); chk_perm(0, "R7");

    // R2 arbitration: snoop and processor together
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = 2'd0; snp_own = 1'b0; snp_src = 3'd7;
    cpu_valid = 1'b1; cpu_op = 2'd0;
    #1;
    check(snp_ready && !cpu_ready && !dat_ready, "R2", longint'({snp_ready, dat_ready, cpu_ready}), 3'b100);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    check(cpu_ready == 1'b1, "R2", longint'(cpu_ready), 1);
    expect_item(0, 0, 0, "R2");
    @(negedge clk);
    cpu_valid = 1'b0;
    snp(0, 1, 0);
    expect_item(2, 'h11, 0, "R4"); dat('h11);
    snp(2, 0, 4); chk_perm(0, "R7");

    // R5: store miss, data first
    expect_item(0, 2, 0, "R3"); cpu(2, 'hB2);
    dat('h55); chk_perm(3, "R5");
    expect_item(3, 0, 0, "R5"); snp(2, 1, 0); chk_perm(2, "R5");
    expect_item(2, 'hB2, 0, "R6"); cpu(0, '0);

    // R7: M supplies data to another read, moves to O
    expect_item(1, 'h04, 'hB2, "R7"); snp(0, 0, 2); chk_perm(1, "R7");

    // R8 / R10: O store, lose to other GETX, own request, record two readers
    expect_item(0, 2, 0, "R8"); cpu(2, 'hC3); chk_perm(3, "R8");
    expect_item(1, 'h02, 'hB2, "R8"); snp(2, 0, 1); chk_perm(3, "R8");
    snp(2, 1, 0);
    snp(0, 0, 5); snp(1, 0, 6);
    expect_item(1, 'h60, 'hC3, "R10"); expect_item(3, 0, 0, "R10");
    dat('h77); chk_perm(1, "R10");

    // R9: writeback from O
    expect_item(0, 3, 'hC3, "R9"); cpu(3, '0); chk_perm(3, "R13");
    expect_item(1, 'h01, 'hC3, "R9"); snp(0, 0, 0);
    expect_item(1, 'h10, 'hC3, "R9"); snp(2, 0, 4); chk_perm(0, "R9");
    snp(0, 0, 3);
    snp(3, 1, 0); chk_perm(0, "R9");

    // R12 / R11: ifetch miss, retry, other writeback ignored, lost read
    expect_item(0, 1, 0, "R3"); cpu(1, '0);
    expect_item(4, 0, 0, "R12"); cpu(0, '0); chk_perm(3, "R12");
    snp(3, 0, 2); chk_perm(3, "R12");
    snp(1, 1, 0); snp(2, 0, 6); chk_perm(3, "R11");
    expect_item(2, 'h99, 0, "R11"); dat('h99); chk_perm(0, "R11");

    // R10: store with a snooped GETX while waiting, ends in I
    expect_item(0, 2, 0, "R10"); cpu(2, 'hD4);
    snp(2, 1, 0); snp(2, 0, 3);
    expect_item(1, 'h08, 'hD4, "R10"); expect_item(3, 0, 0, "R10");
    dat('h12); chk_perm(0, "R10");

    // R9 / R13: writeback from M
    expect_item(0, 2, 0, "R3"); cpu(2, 'hE5);
    snp(2, 1, 0);
    expect_item(3, 0, 0, "R4"); dat('h01); chk_perm(2, "R13");
    expect_item(0, 3, 'hE5, "R9"); cpu(3, '0); chk_perm(0, "R13");
    snp(3, 1, 0); chk_perm(0, "R9");

    // R14: data in a stable state, then flag stays set
    check(proto_err == 1'b0, "R14", longint'(proto_err), 0);
    dat('h33);
    check(proto_err == 1'b1, "R14", longint'(proto_err), 1);
    snp(0, 0, 1);
    check(proto_err == 1'b1, "R14", longint'(proto_err), 1);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R4", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule